// File: doc/BRIEF.md
# Widening Saturating Scaled Multiply-Accumulate Lane

This block is one lane of a fixed-point vector datapath. Each accepted request multiplies two element operands into a product of twice the element width. The product is scaled down by half the element width, with one of four rounding modes, and is then added to or subtracted from an accumulator of twice the element width with saturation. The element width can be 8, 16 or 32 bits and is chosen per request. The second multiplier operand comes either from a vector source or from a scalar source, and the scalar is truncated to the element width.

Four signedness variants choose how the operands and the accumulator are read, and whether the scaled product is added or subtracted. The result is registered. A saturation event is reported with the result and also kept in a sticky flag until software clears it. Requests that cannot be executed raise an error pulse instead of a result. Element sequencing, masking and register access belong to the surrounding unit.

Top module: `wsmac_lane`

## Requirements
- R1: Variant code 0 (unsigned): both operands and the accumulator are unsigned. The result is acc + scaled, clamped to 2^(2*SEW)-1.
- R2: Variant code 1 (signed): both operands and the accumulator are signed. The result is acc + scaled, clamped to the signed 2*SEW range.
- R3: Variant code 2: `src_a` is unsigned and the second operand is signed. The result is acc - scaled, clamped to the signed 2*SEW range.
- R4: Variant code 3: `src_a` is signed and the scalar is unsigned. The result is acc - scaled, clamped to the signed 2*SEW range. This variant is legal only when `scalar_form`=1.
- R5: `sew_sel` codes 0, 1 and 2 select SEW of 8, 16 and 32. The scale step is an arithmetic right shift of the exact product by SEW/2 (4, 8 or 16 bits).
- R6: `rnd_mode` sets the increment added to the shifted product. With h the highest dropped bit, t any lower dropped bit and q0 the kept LSB: code 0 adds h; code 1 adds h&(t|q0); code 2 adds 0; code 3 adds 1 when q0=0 and any dropped bit is set.
- R7: With `scalar_form`=1, the low SEW bits of `src_scalar` replace `src_b`. `src_b` and the scalar bits above SEW have no effect.
- R8: `sat_out` is 1 together with a result exactly when that result was clamped to a bound.
- R9: `sat_sticky` is set by any clamped result and holds until `sat_clr` is 1. A clamp in the same cycle as a clear leaves it set.
- R10: `out_valid` and `acc_out` follow an accepted `in_valid` by exactly one clock.
- R11: A request with `sew_sel`=3, or with variant 3 and `scalar_form`=0, produces `err_out`=1 one clock later and no `out_valid`. `acc_out` and `sat_sticky` keep their values.
- R12: A synchronous active-high `rst` clears `out_valid`, `err_out`, `sat_out`, `sat_sticky` and `acc_out`.
- R13: Operand bits above SEW and accumulator bits above 2*SEW are ignored. `acc_out` bits above 2*SEW are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| variant | input | 2 | Signedness variant code (0..3) |
| scalar_form | input | 1 | 1: second operand taken from `src_scalar` |
| sew_sel | input | 2 | Element width code (0:8, 1:16, 2:32, 3:illegal) |
| rnd_mode | input | 2 | Rounding mode code |
| src_a | input | 32 | First multiplier operand (low SEW bits) |
| src_b | input | 32 | Second multiplier operand, vector form |
| src_scalar | input | 32 | Second multiplier operand, scalar form |
| acc_in | input | 64 | Accumulator (low 2*SEW bits) |
| sat_clr | input | 1 | Clears the sticky saturation flag |
| out_valid | output | 1 | Result strobe |
| acc_out | output | 64 | New accumulator value, zero-extended above 2*SEW |
| sat_out | output | 1 | Result was clamped |
| sat_sticky | output | 1 | Sticky saturation flag |
| err_out | output | 1 | Illegal request pulse |

## Verification
The bench targets rounding ties: a product whose dropped bits sit exactly at one half, tried with odd and even kept LSBs. A wrong tie rule shows up as a result off by one in the LSB. It drives accumulators next to both signed bounds and the unsigned maximum. A design that wraps instead of clamping, or that clamps a subtract against the wrong bound, then gives a sign-flipped value and no saturation flag. It sends operands with junk above SEW and scalar values with junk above SEW, which catches missing truncation or a sign extension taken from the wrong bit. Illegal requests are mixed into random traffic, so a design that still updates the accumulator or the sticky flag on an illegal request is caught at the next comparison.

// File: rtl/wsmac_pkg.sv
package wsmac_pkg;

    typedef enum logic [1:0] {
        VAR_UU = 2'd0,
        VAR_SS = 2'd1,
        VAR_SU = 2'd2,
        VAR_US = 2'd3
    } wsmac_var_e;

    typedef enum logic [1:0] {
        RND_NEAR_UP   = 2'd0,
        RND_NEAR_EVEN = 2'd1,
        RND_TRUNC     = 2'd2,
        RND_ODD       = 2'd3
    } wsmac_rnd_e;

    // number of element widths (8, 16, 32, ...) supported up to a maximum
    function automatic int sew_count(input int ew_max);
        return $clog2(ew_max / 8) + 1;
    endfunction

endpackage

// File: rtl/wsmac_prod.sv
module wsmac_prod #(
    parameter int EW_MAX = 32
) (
    input  logic [1:0]                  sew,
    input  logic                        a_sgn,
    input  logic                        b_sgn,
    input  logic [EW_MAX-1:0]           a,
    input  logic [EW_MAX-1:0]           b,
    output logic signed [2*EW_MAX+1:0]  prod
);
    import wsmac_pkg::*;

    localparam int NSEW = sew_count(EW_MAX);

    logic signed [EW_MAX:0] a_ext [NSEW];
    logic signed [EW_MAX:0] b_ext [NSEW];
    logic signed [EW_MAX:0] a_sel;
    logic signed [EW_MAX:0] b_sel;
    logic [1:0]             idx;

    // one sign/zero extension per supported element width
    for (genvar k = 0; k < NSEW; k++) begin : g_ext
        localparam int W = 8 << k;
        assign a_ext[k] = {{(EW_MAX + 1 - W){a_sgn & a[W-1]}}, a[W-1:0]};
        assign b_ext[k] = {{(EW_MAX + 1 - W){b_sgn & b[W-1]}}, b[W-1:0]};
    end

    always_comb begin
        idx   = (32'(sew) < 32'(NSEW)) ? sew : 2'd0;
        a_sel = a_ext[idx];
        b_sel = b_ext[idx];
        prod  = a_sel * b_sel;
    end

endmodule

// File: rtl/wsmac_scale.sv
module wsmac_scale #(
    parameter int PW = 66
) (
    input  logic signed [PW-1:0]      prod,
    input  logic [$clog2(PW)-1:0]     sh,
    input  logic [1:0]                rmode,
    output logic signed [PW-1:0]      scaled
);
    import wsmac_pkg::*;

    localparam int SHW = $clog2(PW);

    logic [PW-1:0]          ones;
    logic [SHW-1:0]         sh_m1;
    logic signed [PW-1:0]   quo;
    logic                   half_bit;
    logic                   tail_any;
    logic                   drop_any;
    logic                   inc;

    always_comb begin
        ones     = '1;
        sh_m1    = sh - 1'b1;
        quo      = prod >>> sh;
        half_bit = prod[sh_m1];
        tail_any = |(prod & ~(ones << sh_m1));
        drop_any = |(prod & ~(ones << sh));
        unique case (wsmac_rnd_e'(rmode))
            RND_NEAR_UP:   inc = half_bit;
            RND_NEAR_EVEN: inc = half_bit & (tail_any | quo[0]);
            RND_TRUNC:     inc = 1'b0;
            RND_ODD:       inc = ~quo[0] & drop_any;
            default:       inc = 1'b0;
        endcase
        scaled = quo + $signed({{(PW-1){1'b0}}, inc});
    end

endmodule

// File: rtl/wsmac_accum.sv
module wsmac_accum #(
    parameter int EW_MAX = 32
) (
    input  logic [1:0]                  sew,
    input  logic                        acc_sgn,
    input  logic                        do_sub,
    input  logic [2*EW_MAX-1:0]         acc_in,
    input  logic signed [2*EW_MAX+1:0]  scaled,
    output logic [2*EW_MAX-1:0]         res,
    output logic                        sat
);
    import wsmac_pkg::*;

    localparam int NSEW = sew_count(EW_MAX);
    localparam int AW   = 2 * EW_MAX;
    localparam int PW   = 2 * EW_MAX + 2;
    localparam int SW   = PW + 2;

    logic signed [SW-1:0] acc_ext [NSEW];
    logic signed [SW-1:0] hi_arr  [NSEW];
    logic signed [SW-1:0] lo_arr  [NSEW];
    logic [SW-1:0]        msk_arr [NSEW];

    logic [1:0]           idx;
    logic signed [SW-1:0] acc_x;
    logic signed [SW-1:0] sc_x;
    logic signed [SW-1:0] sum;
    logic signed [SW-1:0] hi;
    logic signed [SW-1:0] lo;
    logic signed [SW-1:0] clamped;
    logic [SW-1:0]        masked;

    for (genvar k = 0; k < NSEW; k++) begin : g_width
        localparam int DW = 16 << k;
        localparam logic [SW-1:0] ONE = SW'(1);
        assign acc_ext[k] = {{(SW - DW){acc_sgn & acc_in[DW-1]}}, acc_in[DW-1:0]};
        assign msk_arr[k] = (ONE << DW) - ONE;
        assign hi_arr[k]  = acc_sgn ? $signed((ONE << (DW - 1)) - ONE)
                                    : $signed((ONE << DW) - ONE);
        assign lo_arr[k]  = acc_sgn ? -$signed(ONE << (DW - 1)) : '0;
    end

    always_comb begin
        idx   = (32'(sew) < 32'(NSEW)) ? sew : 2'd0;
        acc_x = acc_ext[idx];
        hi    = hi_arr[idx];
        lo    = lo_arr[idx];
        sc_x  = {{2{scaled[PW-1]}}, scaled};
        sum   = do_sub ? (acc_x - sc_x) : (acc_x + sc_x);
        sat   = 1'b0;
        if (sum > hi) begin
            clamped = hi;
            sat     = 1'b1;
        end else if (sum < lo) begin
            clamped = lo;
            sat     = 1'b1;
        end else begin
            clamped = sum;
        end
        masked = clamped & msk_arr[idx];
        res    = masked[AW-1:0];
    end

endmodule

// File: rtl/wsmac_lane.sv
module wsmac_lane #(
    parameter int EW_MAX = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    input  logic [1:0]            variant,
    input  logic                  scalar_form,
    input  logic [1:0]            sew_sel,
    input  logic [1:0]            rnd_mode,
    input  logic [EW_MAX-1:0]     src_a,
    input  logic [EW_MAX-1:0]     src_b,
    input  logic [EW_MAX-1:0]     src_scalar,
    input  logic [2*EW_MAX-1:0]   acc_in,
    input  logic                  sat_clr,
    output logic                  out_valid,
    output logic [2*EW_MAX-1:0]   acc_out,
    output logic                  sat_out,
    output logic                  sat_sticky,
    output logic                  err_out
);
    import wsmac_pkg::*;

    localparam int NSEW = sew_count(EW_MAX);
    localparam int AW   = 2 * EW_MAX;
    localparam int PW   = 2 * EW_MAX + 2;
    localparam int SHW  = $clog2(PW);

    typedef struct packed {
        logic          vld;
        logic          err;
        logic          sat;
        logic          stk;
        logic [AW-1:0] acc;
    } lane_st_t;

    lane_st_t st_d, st_q;

    logic                  legal;
    logic                  a_sgn, b_sgn, acc_sgn, do_sub;
    logic [EW_MAX-1:0]     b_src;
    logic [SHW-1:0]        shift_amt;
    logic signed [PW-1:0]  prod;
    logic signed [PW-1:0]  scaled;
    logic [AW-1:0]         acc_new;
    logic                  acc_sat;

    // request decode
    always_comb begin
        legal     = (32'(sew_sel) < 32'(NSEW)) &&
                    !((wsmac_var_e'(variant) == VAR_US) && !scalar_form);
        a_sgn     = (wsmac_var_e'(variant) == VAR_SS) || (wsmac_var_e'(variant) == VAR_US);
        b_sgn     = (wsmac_var_e'(variant) == VAR_SS) || (wsmac_var_e'(variant) == VAR_SU);
        acc_sgn   = (wsmac_var_e'(variant) != VAR_UU);
        do_sub    = variant[1];
        b_src     = scalar_form ? src_scalar : src_b;
        shift_amt = SHW'(4) << sew_sel;
    end

    wsmac_prod #(.EW_MAX(EW_MAX)) u_prod (
        .sew   (sew_sel),
        .a_sgn (a_sgn),
        .b_sgn (b_sgn),
        .a     (src_a),
        .b     (b_src),
        .prod  (prod)
    );

    wsmac_scale #(.PW(PW)) u_scale (
        .prod   (prod),
        .sh     (shift_amt),
        .rmode  (rnd_mode),
        .scaled (scaled)
    );

    wsmac_accum #(.EW_MAX(EW_MAX)) u_accum (
        .sew     (sew_sel),
        .acc_sgn (acc_sgn),
        .do_sub  (do_sub),
        .acc_in  (acc_in),
        .scaled  (scaled),
        .res     (acc_new),
        .sat     (acc_sat)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        st_d.err = 1'b0;
        st_d.sat = 1'b0;
        if (sat_clr) st_d.stk = 1'b0;
        if (in_valid) begin
            if (legal) begin
                st_d.vld = 1'b1;
                st_d.acc = acc_new;
                st_d.sat = acc_sat;
                if (acc_sat) st_d.stk = 1'b1;
            end else begin
                st_d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign out_valid  = st_q.vld;
    assign err_out    = st_q.err;
    assign sat_out    = st_q.sat;
    assign sat_sticky = st_q.stk;
    assign acc_out    = st_q.acc;

    // R10: a result strobe is always caused by a request one clock earlier
    assert_latency_R10: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !$past(rst)) |-> $past(in_valid));

    // R11: an error pulse never comes with a result
    assert_err_excl_R11: assert property (@(posedge clk) disable iff (rst)
        err_out |-> !out_valid);

    // R11: accumulator holds across cycles without a result
    assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (!out_valid && !$past(rst)) |-> $stable(acc_out));

    // R9: a clamped result is always reflected in the sticky flag
    assert_sticky_set_R9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && sat_out) |-> sat_sticky);

    // R9: sticky flag only drops after a clear request
    assert_sticky_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(sat_sticky) && !$past(sat_clr)) |-> sat_sticky);

    // R8: saturation indication only accompanies a result
    assert_sat_valid_R8: assert property (@(posedge clk) disable iff (rst)
        sat_out |-> out_valid);

    // R13: bits above 2*SEW of a fresh result are zero
    assert_upper_zero_R13: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !$past(rst)) |-> ((acc_out >> (16 << $past(sew_sel))) == '0));

endmodule

// File: tb/wsmac_lane_bench.sv
`timescale 1ns/1ps
module wsmac_lane_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [1:0]  variant;
    logic        scalar_form;
    logic [1:0]  sew_sel;
    logic [1:0]  rnd_mode;
    logic [31:0] src_a, src_b, src_scalar;
    logic [63:0] acc_in;
    logic        sat_clr;
    logic        out_valid;
    logic [63:0] acc_out;
    logic        sat_out, sat_sticky, err_out;

    always #2 clk = ~clk;

    wsmac_lane u_wsmac_lane (
        .clk(clk), .rst(rst), .in_valid(in_valid), .variant(variant),
        .scalar_form(scalar_form), .sew_sel(sew_sel), .rnd_mode(rnd_mode),
        .src_a(src_a), .src_b(src_b), .src_scalar(src_scalar), .acc_in(acc_in),
        .sat_clr(sat_clr), .out_valid(out_valid), .acc_out(acc_out),
        .sat_out(sat_out), .sat_sticky(sat_sticky), .err_out(err_out)
    );

    int    n_checks = 0;
    int    n_errors = 0;
    bit    finished = 1'b0;
    string cur_tag  = "R12";

    bit          e_vld, e_err, e_sat, e_stk;
    logic [63:0] e_acc;

    // behavioural reference for one element operation
    function automatic void ref_op(input int vr, input bit sf, input int sw, input int rm,
                                   input logic [31:0] a, input logic [31:0] b,
                                   input logic [31:0] sc, input logic [63:0] acc,
                                   output logic [63:0] res, output bit sat);
        logic signed [127:0] one, av, bv, p, q, r, half, inc, accv, t, hi, lo, msk;
        int ew, d;
        one  = 1;
        ew   = 8 << sw;
        d    = ew / 2;
        av   = a & ((one << ew) - one);
        if ((vr == 1 || vr == 3) && av[ew-1]) av = av - (one << ew);
        bv   = (sf ? sc : b) & ((one << ew) - one);
        if ((vr == 1 || vr == 2) && bv[ew-1]) bv = bv - (one << ew);
        p    = av * bv;
        q    = p >>> d;
        r    = p - (q <<< d);
        half = one << (d - 1);
        case (rm)
            0:       inc = (r >= half) ? one : 0;
            1:       inc = ((r > half) || (r == half && q[0])) ? one : 0;
            2:       inc = 0;
            default: inc = (r != 0 && !q[0]) ? one : 0;
        endcase
        q    = q + inc;
        msk  = (one << (2 * ew)) - one;
        accv = acc & msk;
        if (vr != 0 && accv[2*ew-1]) accv = accv - (one << (2 * ew));
        t    = (vr < 2) ? accv + q : accv - q;
        if (vr == 0) begin
            hi = msk;
            lo = 0;
        end else begin
            hi = (one << (2 * ew - 1)) - one;
            lo = -(one << (2 * ew - 1));
        end
        sat = 1'b0;
        if (t > hi) begin t = hi; sat = 1'b1; end
        else if (t < lo) begin t = lo; sat = 1'b1; end
        t   = t & msk;
        res = t[63:0];
    endfunction

    task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%h expected=%h", cur_tag, what, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("out_valid",  64'(out_valid),  64'(e_vld));
        chk("err_out",    64'(err_out),    64'(e_err));
        chk("sat_out",    64'(sat_out),    64'(e_sat));
        chk("sat_sticky", 64'(sat_sticky), 64'(e_stk));
        chk("acc_out",    acc_out,         e_acc);
    endtask

    // one clock: check last cycle's result, then present the next request
    task automatic op(input string tag, input bit vin, input int vr, input bit sf,
                      input int sw, input int rm, input logic [31:0] a, input logic [31:0] b,
                      input logic [31:0] sc, input logic [63:0] acc, input bit clr);
        logic [63:0] res;
        bit sat, legal;
        @(negedge clk);
        compare_all();
        in_valid    = vin;
        variant     = 2'(vr);
        scalar_form = sf;
        sew_sel     = 2'(sw);
        rnd_mode    = 2'(rm);
        src_a       = a;
        src_b       = b;
        src_scalar  = sc;
        acc_in      = acc;
        sat_clr     = clr;
        cur_tag     = tag;
        legal = (sw < 3) && !(vr == 3 && !sf);
        e_vld = vin && legal;
        e_err = vin && !legal;
        e_sat = 1'b0;
        if (clr) e_stk = 1'b0;
        if (e_vld) begin
            ref_op(vr, sf, sw, rm, a, b, sc, acc, res, sat);
            e_acc = res;
            e_sat = sat;
            if (sat) e_stk = 1'b1;
        end
    endtask

    task automatic idle(input string tag);
        op(tag, 1'b0, 0, 1'b0, 0, 0, 32'h0, 32'h0, 32'h0, 64'h0, 1'b0);
    endtask

    initial begin
        rst = 1'b1; in_valid = 1'b0; variant = '0; scalar_form = 1'b0; sew_sel = '0;
        rnd_mode = '0; src_a = '0; src_b = '0; src_scalar = '0; acc_in = '0; sat_clr = 1'b0;
        e_vld = 0; e_err = 0; e_sat = 0; e_stk = 0; e_acc = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // first compare inside op() checks the reset state (R12)
        op("R1", 1, 0, 0, 0, 2, 32'hFF, 32'hFF, 0, 64'h0010, 0);
        op("R1", 1, 0, 0, 0, 0, 32'hFF, 32'hFF, 0, 64'hFFF0, 0);
        op("R9", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        op("R9", 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
        op("R2", 1, 1, 0, 1, 0, 32'h8000, 32'h8000, 0, 64'h7FF0_0000, 0);
        op("R2", 1, 1, 0, 1, 1, 32'h8000, 32'h7FFF, 0, 64'h8000_0000, 1);
        op("R2", 1, 1, 0, 1, 0, 32'h1234, 32'hFF00, 0, 64'h0000_1000, 1);
        op("R3", 1, 2, 0, 0, 0, 32'hF0, 32'h10, 0, 64'h0064, 0);
        op("R3", 1, 2, 0, 0, 0, 32'hF0, 32'h10, 0, 64'h8000, 0);
        op("R3", 1, 2, 1, 0, 0, 32'hF0, 32'h0, 32'hF0, 64'h7F00, 1);
        op("R4", 1, 3, 1, 2, 0, 32'hFFFF_FFFF, 32'h0, 32'h0000_1000, 64'h5, 0);
        op("R4", 1, 3, 1, 2, 3, 32'h8000_0000, 32'h0, 32'hFFFF_FFFF, 64'h7FFF_FFFF_FFFF_FFFF, 1);
        for (int m = 0; m < 4; m++) begin
            op("R6", 1, 0, 0, 0, m, 32'h3, 32'h8, 0, 64'h0, 0);
            op("R6", 1, 0, 0, 0, m, 32'h1, 32'h8, 0, 64'h0, 0);
            op("R6", 1, 0, 0, 0, m, 32'h1, 32'h9, 0, 64'h0, 0);
            op("R6", 1, 1, 0, 1, m, 32'hFF80, 32'h0003, 0, 64'h0, 0);
        end
        op("R5", 1, 0, 0, 2, 2, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 64'h0, 0);
        op("R5", 1, 0, 0, 1, 2, 32'hFFFF, 32'hFFFF, 0, 64'h0, 0);
        op("R7", 1, 0, 1, 0, 2, 32'h0000_0040, 32'h55, 32'hFFFF_FF02, 64'h0, 0);
        op("R7", 1, 1, 1, 1, 2, 32'h0000_0100, 32'h7777, 32'hABCD_FFFF, 64'h0, 0);
        op("R13", 1, 1, 0, 0, 0, 32'hABCD_1280, 32'h9999_99F0, 0, 64'hDEAD_BEEF_CAFE_0100, 0);
        op("R10", 1, 0, 0, 0, 0, 32'h11, 32'h22, 0, 64'h0, 0);
        idle("R10");
        op("R11", 1, 0, 0, 3, 0, 32'hFF, 32'hFF, 0, 64'hFFFF, 0);
        op("R11", 1, 3, 0, 0, 0, 32'h80, 32'hFF, 0, 64'h8000, 0);
        idle("R11");
        for (int i = 0; i < 400; i++) begin
            int vr, sw, rm;
            logic [63:0] acc;
            string tg;
            vr  = int'($urandom_range(0, 3));
            sw  = ($urandom_range(0, 9) == 0) ? 3 : int'($urandom_range(0, 2));
            rm  = int'($urandom_range(0, 3));
            acc = {$urandom, $urandom};
            if ($urandom_range(0, 3) == 0) acc = acc | 64'h7FFF_FFFF_FFFF_FF00;
            case (vr)
                0: tg = "R1";
                1: tg = "R2";
                2: tg = "R3";
                default: tg = "R4";
            endcase
            if (sw == 3) tg = "R11";
            op(tg, $urandom_range(0, 4) != 0, vr, $urandom_range(0, 1) == 1, sw, rm,
               $urandom, $urandom, $urandom, acc, $urandom_range(0, 15) == 0);
        end
        idle("R8");
        idle("R9");
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL R10 watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule